// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block steps a processor subsystem through five operating states: full run, doze, sleep, deep sleep and stop. Each state has a fixed set of power-domain enables. Software requests a state while the subsystem is in full run. Any unmasked wake event brings it back to full run. The deeper the state, the longer the return path: from deep sleep the return waits for PLL lock. From stop it first restores the restart domain, then the PLL, waits for lock, and then holds a fixed settle window before the core comes back.

In full run a gear divider thins the core clock. It emits a one-cycle clock-enable pulse once every 1, 2, 4 or 8 cycles. A new gear setting is only picked up at the end of a divider period, so no pulse is ever shortened. A status output always shows the state encoding.

Top module: `pwr_mode_seq`

## Requirements
- R1: After reset the status reads 0 (full run), all eight domain enables are 1 and the core clock enable is high every cycle (divide-by-1).
- R2: Domain enable bit positions are: 0 core, 1 timebase, 2 decrementer, 3 PLL, 4 memory controller, 5 RTC, 6 PIT, 7 restart. In full run the enable vector is 8'hFF.
- R3: In doze (status 1) the enable vector is 8'hBE: core and PIT are off, and timebase, decrementer, PLL, memory controller, RTC and restart are on.
- R4: In sleep (status 2) the enables are 8'hE8 (PLL, RTC, PIT, restart). In deep sleep (status 3) they are 8'hE0. In stop (status 4) they are 8'h00.
- R5: In full run, a request with code 1 (doze), 2 (sleep), 3 (deep sleep) or 4 (stop) moves the status to that code on the next clock edge. Codes 0, 5, 6 and 7 leave the state in full run.
- R6: A request made in any state other than full run is ignored.
- R7: A wake occurs only when some bit of the wake events AND the wake enables is 1. Masked events leave the state unchanged. Wake events in full run have no effect.
- R8: A wake in doze or sleep returns the status to 0 on the next edge.
- R9: A wake in deep sleep enters PLL wait (status 6, enables 8'hE8). The block stays there while PLL lock is low and returns to full run on the edge after lock is seen high.
- R10: A wake in stop gives restart-only (status 5, enables 8'h80) for one cycle, then PLL wait (status 6, 8'h88) until lock, then settle (status 7, 8'h88) for exactly 16 cycles, then full run.
- R11: In full run, gear setting g (0..3) gives one core clock-enable pulse every 2^g cycles. Outside full run the core clock enable is low.
- R12: A change of gear setting takes effect only after the current divider period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Mode request strobe |
| req_mode | input | 3 | Requested state code |
| gear_sel | input | 2 | Core divide setting, divide by 2^gear_sel |
| wake_evt | input | 4 | Wake event lines |
| wake_en | input | 4 | Per-line wake enables |
| pll_lock | input | 1 | PLL lock indication |
| dom_en | output | 8 | Per-domain enables |
| core_clk_en | output | 1 | Divided core clock-enable pulse |
| state_o | output | 3 | Current state encoding |

## Verification
A wrong state register shows at once. The status output and the enable vector both decode from it, so a bad transition is visible in the first cycle after the offending edge. A settle counter that is off by one moves the return to full run by one cycle. Counting the cycles spent in status 7 exposes it. A gear register that loads outside the period boundary shows as a shortened pulse gap on the core clock enable, one divider period after the change.

// File: rtl/pwr_mode_seq_pkg.sv
package pwr_mode_seq_pkg;

    typedef enum logic [2:0] {
        PS_RUN    = 3'd0,
        PS_DOZE   = 3'd1,
        PS_SLEEP  = 3'd2,
        PS_DEEP   = 3'd3,
        PS_STOP   = 3'd4,
        PS_WRST   = 3'd5,
        PS_WPLL   = 3'd6,
        PS_SETTLE = 3'd7
    } pwr_state_e;

    localparam int DOM_N     = 8;
    localparam int DOM_CORE  = 0;
    localparam int DOM_TB    = 1;
    localparam int DOM_DEC   = 2;
    localparam int DOM_PLL   = 3;
    localparam int DOM_MC    = 4;
    localparam int DOM_RTC   = 5;
    localparam int DOM_PIT   = 6;
    localparam int DOM_RST   = 7;

endpackage

// File: rtl/pwr_gear_div.sv
module pwr_gear_div #(
    parameter int GEAR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [GEAR_W-1:0] gear_sel,
    output logic              tick
);
    localparam int CNT_W = (1 << GEAR_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [GEAR_W-1:0] gear;
    } div_t;

    div_t             cur_q, nxt_d;
    logic [CNT_W-1:0] lim;

    always_comb begin
        lim   = CNT_W'((1 << cur_q.gear) - 1);
        nxt_d = cur_q;
        if (!run) begin
            nxt_d.cnt  = '0;
            nxt_d.gear = gear_sel;
        end else if (cur_q.cnt == lim) begin
            // period boundary: restart and pick up the new setting
            nxt_d.cnt  = '0;
            nxt_d.gear = gear_sel;
        end else begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign tick = run && (cur_q.cnt == '0);

    // R11: counter never runs past the current period
    a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= lim);

    // R12: gear setting only moves at a period end or outside run
    a_r12_gear_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cur_q.cnt != lim) |=> $stable(cur_q.gear));

endmodule

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_mode_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_mode,
    input  logic       wake,
    input  logic       pll_lock,
    output pwr_state_e state,
    output logic       from_stop
);
    localparam int SC_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

    typedef struct packed {
        pwr_state_e  st;
        logic [SC_W-1:0] cnt;
        logic        stop_path;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.st)
            PS_RUN: begin
                if (req_valid && req_mode >= 3'd1 && req_mode <= 3'd4)
                    nxt_d.st = pwr_state_e'(req_mode);
            end
            PS_DOZE, PS_SLEEP: begin
                if (wake) nxt_d.st = PS_RUN;
            end
            PS_DEEP: begin
                if (wake) begin
                    nxt_d.st        = PS_WPLL;
                    nxt_d.stop_path = 1'b0;
                end
            end
            PS_STOP: begin
                if (wake) begin
                    nxt_d.st        = PS_WRST;
                    nxt_d.stop_path = 1'b1;
                end
            end
            PS_WRST: nxt_d.st = PS_WPLL;
            PS_WPLL: begin
                if (pll_lock) begin
                    if (cur_q.stop_path) begin
                        nxt_d.st  = PS_SETTLE;
                        nxt_d.cnt = SC_W'(SETTLE_CYC - 1);
                    end else begin
                        nxt_d.st = PS_RUN;
                    end
                end
            end
            PS_SETTLE: begin
                if (cur_q.cnt == '0) begin
                    nxt_d.st        = PS_RUN;
                    nxt_d.stop_path = 1'b0;
                end else begin
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                end
            end
            default: nxt_d.st = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{st: PS_RUN, cnt: '0, stop_path: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign state     = cur_q.st;
    assign from_stop = cur_q.stop_path;

    // R6: doze holds against requests when no wake arrives
    a_r6_doze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PS_DOZE && !wake) |=> cur_q.st == PS_DOZE);

    // R8: sleep returns to run in one cycle
    a_r8_sleep_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PS_SLEEP && wake) |=> cur_q.st == PS_RUN);

    // R9: no exit from PLL wait without lock
    a_r9_wait_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == PS_WPLL && !pll_lock) |=> cur_q.st == PS_WPLL);

    // R10: restart-only phase lasts one cycle
    a_r10_restart_one: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.st == PS_WRST |=> cur_q.st == PS_WPLL);

endmodule

// File: rtl/pwr_dom_map.sv
module pwr_dom_map
    import pwr_mode_seq_pkg::*;
(
    input  pwr_state_e       state,
    input  logic             from_stop,
    output logic [DOM_N-1:0] dom_en
);
    always_comb begin
        dom_en = '0;
        unique case (state)
            PS_RUN:   dom_en = '1;
            PS_DOZE: begin
                dom_en[DOM_TB]  = 1'b1;
                dom_en[DOM_DEC] = 1'b1;
                dom_en[DOM_PLL] = 1'b1;
                dom_en[DOM_MC]  = 1'b1;
                dom_en[DOM_RTC] = 1'b1;
                dom_en[DOM_RST] = 1'b1;
            end
            PS_SLEEP: begin
                dom_en[DOM_PLL] = 1'b1;
                dom_en[DOM_RTC] = 1'b1;
                dom_en[DOM_PIT] = 1'b1;
                dom_en[DOM_RST] = 1'b1;
            end
            PS_DEEP: begin
                dom_en[DOM_RTC] = 1'b1;
                dom_en[DOM_PIT] = 1'b1;
                dom_en[DOM_RST] = 1'b1;
            end
            PS_STOP:  dom_en = '0;
            PS_WRST:  dom_en[DOM_RST] = 1'b1;
            PS_WPLL, PS_SETTLE: begin
                dom_en[DOM_RST] = 1'b1;
                dom_en[DOM_PLL] = 1'b1;
                dom_en[DOM_RTC] = !from_stop;
                dom_en[DOM_PIT] = !from_stop;
            end
            default:  dom_en = '0;
        endcase
    end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pwr_mode_seq_pkg::*;
#(
    parameter int N_WAKE     = 4,
    parameter int GEAR_W     = 2,
    parameter int SETTLE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic [GEAR_W-1:0] gear_sel,
    input  logic [N_WAKE-1:0] wake_evt,
    input  logic [N_WAKE-1:0] wake_en,
    input  logic              pll_lock,
    output logic [DOM_N-1:0]  dom_en,
    output logic              core_clk_en,
    output logic [2:0]        state_o
);
    pwr_state_e st;
    logic       from_stop;
    logic       wake_any;

    assign wake_any = |(wake_evt & wake_en);

    pwr_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (req_mode),
        .wake      (wake_any),
        .pll_lock  (pll_lock),
        .state     (st),
        .from_stop (from_stop)
    );

    pwr_dom_map u_map (
        .state     (st),
        .from_stop (from_stop),
        .dom_en    (dom_en)
    );

    pwr_gear_div #(.GEAR_W(GEAR_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st == PS_RUN),
        .gear_sel (gear_sel),
        .tick     (core_clk_en)
    );

    assign state_o = st;

    // R11: core clock pulses only while the core domain is enabled
    a_r11_tick_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
        core_clk_en |-> dom_en[DOM_CORE]);

    // R4: the restart domain is off only in stop
    a_r4_restart_off_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !dom_en[DOM_RST] |-> state_o == 3'd4);

endmodule

// File: tb/pwr_mode_seq_bench.sv
module pwr_mode_seq_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_mode = '0;
    logic [1:0] gear_sel = '0;
    logic [3:0] wake_evt = '0;
    logic [3:0] wake_en = '0;
    logic       pll_lock = 1'b0;
    logic [7:0] dom_en;
    logic       core_clk_en;
    logic [2:0] state_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pwr_mode_seq u_pwr_mode_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .gear_sel(gear_sel), .wake_evt(wake_evt), .wake_en(wake_en),
        .pll_lock(pll_lock), .dom_en(dom_en), .core_clk_en(core_clk_en),
        .state_o(state_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic request(input logic [2:0] code);
        req_valid = 1'b1; req_mode = code;
        step();
        req_valid = 1'b0; req_mode = '0;
    endtask

    task automatic pulse_wake();
        wake_evt = 4'b0100; wake_en = 4'b0100;
        step();
        wake_evt = '0;
    endtask

    task automatic t_reset();
        chk("R1 state", {5'd0, state_o}, 8'd0);
        chk("R1/R2 enables", dom_en, 8'hFF);
        chk("R1 clk_en", {7'd0, core_clk_en}, 8'd1);
        step();
        chk("R1 clk_en div1", {7'd0, core_clk_en}, 8'd1);
    endtask

    task automatic t_bad_codes();
        for (int c = 5; c < 8; c++) begin
            request(3'(c));
            chk("R5 bad code ignored", {5'd0, state_o}, 8'd0);
        end
        request(3'd0);
        chk("R5 code0 ignored", {5'd0, state_o}, 8'd0);
        wake_evt = 4'hF; wake_en = 4'hF;
        step();
        wake_evt = '0;
        chk("R7 wake in run", {5'd0, state_o}, 8'd0);
    endtask

    task automatic t_doze();
        request(3'd1);
        chk("R5 doze entry", {5'd0, state_o}, 8'd1);
        chk("R3 doze enables", dom_en, 8'hBE);
        chk("R11 no tick in doze", {7'd0, core_clk_en}, 8'd0);
        request(3'd2);
        chk("R6 request in doze", {5'd0, state_o}, 8'd1);
        wake_evt = 4'b0010; wake_en = 4'b1101;
        step();
        wake_evt = '0;
        chk("R7 masked wake", {5'd0, state_o}, 8'd1);
        pulse_wake();
        chk("R8 doze wake", {5'd0, state_o}, 8'd0);
        chk("R2 run enables", dom_en, 8'hFF);
    endtask

    task automatic t_sleep();
        request(3'd2);
        chk("R4 sleep state", {5'd0, state_o}, 8'd2);
        chk("R4 sleep enables", dom_en, 8'hE8);
        pulse_wake();
        chk("R8 sleep wake", {5'd0, state_o}, 8'd0);
    endtask

    task automatic t_deep();
        pll_lock = 1'b0;
        request(3'd3);
        chk("R4 deep state", {5'd0, state_o}, 8'd3);
        chk("R4 deep enables", dom_en, 8'hE0);
        request(3'd1);
        chk("R6 request in deep", {5'd0, state_o}, 8'd3);
        pulse_wake();
        chk("R9 pll wait", {5'd0, state_o}, 8'd6);
        chk("R9 pll wait enables", dom_en, 8'hE8);
        for (int i = 0; i < 3; i++) step();
        chk("R9 still waiting", {5'd0, state_o}, 8'd6);
        pll_lock = 1'b1;
        step();
        pll_lock = 1'b0;
        chk("R9 lock to run", {5'd0, state_o}, 8'd0);
    endtask

    task automatic t_stop();
        int settle;
        pll_lock = 1'b0;
        request(3'd4);
        chk("R4 stop state", {5'd0, state_o}, 8'd4);
        chk("R4 stop enables", dom_en, 8'h00);
        pulse_wake();
        chk("R10 restart phase", {5'd0, state_o}, 8'd5);
        chk("R10 restart enables", dom_en, 8'h80);
        step();
        chk("R10 pll phase", {5'd0, state_o}, 8'd6);
        chk("R10 pll enables", dom_en, 8'h88);
        step();
        chk("R10 holds for lock", {5'd0, state_o}, 8'd6);
        pll_lock = 1'b1;
        step();
        pll_lock = 1'b0;
        settle = 0;
        while (state_o == 3'd7 && settle < 40) begin
            if (settle == 0) chk("R10 settle enables", dom_en, 8'h88);
            settle++;
            step();
        end
        chk("R10 settle length", 8'(settle), 8'd16);
        chk("R10 back to run", {5'd0, state_o}, 8'd0);
    endtask

    task automatic t_gear();
        int pulses;
        gear_sel = 2'd2;
        step(); step();
        pulses = 0;
        for (int i = 0; i < 32; i++) begin
            if (core_clk_en) pulses++;
            step();
        end
        chk("R11 div4 pulses", 8'(pulses), 8'd8);
        gear_sel = 2'd3;
        for (int i = 0; i < 6; i++) step();
        pulses = 0;
        for (int i = 0; i < 32; i++) begin
            if (core_clk_en) pulses++;
            step();
        end
        chk("R11 div8 pulses", 8'(pulses), 8'd4);
        while (!core_clk_en) step();
        gear_sel = 2'd0;
        pulses = 0;
        for (int i = 0; i < 7; i++) begin
            step();
            if (core_clk_en) pulses++;
        end
        chk("R12 old period kept", 8'(pulses), 8'd0);
        step();
        chk("R12 boundary pulse", {7'd0, core_clk_en}, 8'd1);
        step();
        chk("R12 new div1", {7'd0, core_clk_en}, 8'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #9 rst_n = 1'b1;
        #2;
        t_reset();
        t_bad_codes();
        t_doze();
        t_sleep();
        t_deep();
        t_stop();
        t_gear();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule